// File: doc/BRIEF.md
# Timer Channel with Raw Event Status

A single 16-bit timer channel with an 8-bit prescaler in front of it. Software sets it up through a flat word-addressed register port. It runs in one of three modes:

- **One-shot:** counts down to zero, or up to the interval value, then stops.
- **Periodic:** counts in the same way, reloads at the limit and keeps running.
- **Edge-time:** the counter wraps freely. The counter and prescaler are latched on each rising edge of a synchronized capture input.

Four event sources feed a read-only raw status word:

- time-out;
- counter match;
- capture match;
- an external RTC strobe.

Each status bit stays set until software writes a 1 to the same bit position of a separate clear register.

The block is meant to sit behind an interrupt mask stage elsewhere in the chip. It gives only the unmasked, sticky event state, plus the live counter and the captured value.

Top module: `gp_timer_chan`

## Requirements
- R1: The status word (address 5) holds the events at fixed bit positions: capture-match at bit 9, time-out at bit 8, match at bit 4 and RTC at bit 3. Every other bit reads 0. Writes to address 5 change nothing.
- R2: After reset, the status, control (address 0), capture (address 7) and live value (address 8) registers all read 0.
- R3: Writing 1 to a bit of the clear register (address 6) clears that status bit. Writing 0 leaves it as it was. A set event in the same cycle as its clear keeps the bit at 1.
- R4: In one-shot (control[1:0]=1) or periodic (control[1:0]=2) mode, time-out sets when a counter step falls due while the counter sits at its limit. The limit is 0 when counting down (control[2]=0) and the interval value (address 1) when counting up (control[2]=1). Edge-time mode (control[1:0]=3) never raises time-out.
- R5: On time-out, periodic mode reloads its start value and keeps the run bit (control[5]) set. One-shot mode clears the run bit and holds the counter.
- R6: Match (bit 4) sets when the counter arrives at the match value (address 2). This needs the match enable (control[3]) to be 1 and the mode to be one-shot or periodic.
- R7: With control[4]=1, a match also needs the prescaler to equal the prescale-match value (address 4). With control[4]=0 the prescaler is ignored.
- R8: In edge-time mode, a rising edge on cap_i, after a two-stage synchronizer, latches {prescaler, counter} into the capture register. In any other mode the capture register is left unchanged. The layout is bits [23:16] prescaler and [15:0] counter, the same as the live value register.
- R9: Capture-match (bit 9) sets when the latched counter and prescaler equal the match and prescale-match registers. It does not set when either differs.
- R10: A one-cycle pulse on rtc_evt_i sets status bit 3 on the next clock edge.
- R11: The prescaler counts from its load value (address 3) toward 0 when counting down, and from 0 toward the load value when counting up. The counter steps once per load+1 cycles.
- R12: Writing the control register reloads the start values one cycle later:
  - counting down: counter = interval and prescaler = prescale load;
  - counting up: both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| cap_i | input | 1 | Asynchronous capture input for edge-time mode |
| rtc_evt_i | input | 1 | Synchronous RTC event strobe |

## Verification
The bench counts exact cycles to the time-out in both count directions, with the prescaler both off and active:

- A design that used the wrong limit for the direction would raise time-out a whole period early or late.
- A design that ignored the prescaler would also raise it a whole period early or late.

It checks clear writes carrying zeros and carrying other bits, and it drives a clear against a same-cycle RTC event. A design where clear won, or where any write cleared the word, would drop the bit.

It gates match by the enable bit, by the mode and by the prescale-match option. A design that missed any of these gates would set bit 4 in runs where it must stay 0.

Capture is pulsed outside edge-time mode and with a wrong match value. A latch or status set in either case would show up as a changed capture word or a stray bit 9.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE      = 2'd0,
    MODE_ONESHOT   = 2'd1,
    MODE_PERIODIC  = 2'd2,
    MODE_EDGE_TIME = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      run;
    logic      match_pre;
    logic      match_ie;
    logic      count_up;
    tmr_mode_e mode;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL      = 4'd0;
  localparam logic [ADDR_W-1:0] A_INTERVAL  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MATCH     = 4'd2;
  localparam logic [ADDR_W-1:0] A_PRE_LOAD  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PRE_MATCH = 4'd4;
  localparam logic [ADDR_W-1:0] A_STATUS    = 4'd5;
  localparam logic [ADDR_W-1:0] A_CLEAR     = 4'd6;
  localparam logic [ADDR_W-1:0] A_CAPTURE   = 4'd7;
  localparam logic [ADDR_W-1:0] A_VALUE     = 4'd8;

  localparam int unsigned STATUS_W = 10;
  localparam int unsigned N_SRC    = 4;
  // source index -> status bit position
  localparam int unsigned SRC_RTC   = 0;
  localparam int unsigned SRC_MATCH = 1;
  localparam int unsigned SRC_TO    = 2;
  localparam int unsigned SRC_CAP   = 3;

  function automatic int unsigned src_bit(input int unsigned s);
    case (s)
      SRC_RTC:   return 3;
      SRC_MATCH: return 4;
      SRC_TO:    return 8;
      default:   return 9;
    endcase
  endfunction
endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output tmr_ctrl_t              ctrl_o,
  output logic [CNT_W-1:0]       interval_o,
  output logic [CNT_W-1:0]       match_o,
  output logic [PRE_W-1:0]       pre_load_o,
  output logic [PRE_W-1:0]       pre_match_o,
  output logic                   load_o,
  input  logic                   stop_i,
  input  logic                   to_evt_i,
  input  logic                   match_evt_i,
  input  logic                   cap_evt_i,
  input  logic                   rtc_evt_i,
  input  logic [CNT_W+PRE_W-1:0] value_i,
  input  logic [CNT_W+PRE_W-1:0] capture_i,
  output logic [STATUS_W-1:0]    raw_o
);
  tmr_ctrl_t           ctrl_q;
  logic [CNT_W-1:0]    interval_q, match_q;
  logic [PRE_W-1:0]    pre_load_q, pre_match_q;
  logic                load_q;
  logic [N_SRC-1:0]    src_q, evt;
  logic                wr_ctrl, wr_clr;
  logic                unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_clr  = wr_en_i && (addr_i == A_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      interval_q  <= '0;
      match_q     <= '0;
      pre_load_q  <= '0;
      pre_match_q <= '0;
      load_q      <= 1'b0;
    end else begin
      load_q <= wr_ctrl;
      // a control write re-arms even if a one-shot stops in the same cycle
      if (wr_ctrl)     ctrl_q     <= tmr_ctrl_t'(wdata_i[CTRL_W-1:0]);
      else if (stop_i) ctrl_q.run <= 1'b0;
      if (wr_en_i && addr_i == A_INTERVAL)  interval_q  <= wdata_i[CNT_W-1:0];
      if (wr_en_i && addr_i == A_MATCH)     match_q     <= wdata_i[CNT_W-1:0];
      if (wr_en_i && addr_i == A_PRE_LOAD)  pre_load_q  <= wdata_i[PRE_W-1:0];
      if (wr_en_i && addr_i == A_PRE_MATCH) pre_match_q <= wdata_i[PRE_W-1:0];
    end
  end

  always_comb begin
    evt            = '0;
    evt[SRC_RTC]   = rtc_evt_i;
    evt[SRC_MATCH] = match_evt_i;
    evt[SRC_TO]    = to_evt_i;
    evt[SRC_CAP]   = cap_evt_i;
  end

  // sticky raw status: set beats clear
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    localparam int unsigned POS = src_bit(s);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_q[s] <= 1'b0;
      else         src_q[s] <= evt[s] | (src_q[s] & ~(wr_clr & wdata_i[POS]));
    end
  end

  always_comb begin
    raw_o = '0;
    for (int s = 0; s < N_SRC; s++) raw_o[src_bit(s)] = src_q[s];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:      rdata_o[CTRL_W-1:0]      = ctrl_q;
      A_INTERVAL:  rdata_o[CNT_W-1:0]       = interval_q;
      A_MATCH:     rdata_o[CNT_W-1:0]       = match_q;
      A_PRE_LOAD:  rdata_o[PRE_W-1:0]       = pre_load_q;
      A_PRE_MATCH: rdata_o[PRE_W-1:0]       = pre_match_q;
      A_STATUS:    rdata_o[STATUS_W-1:0]    = raw_o;
      A_CAPTURE:   rdata_o[CNT_W+PRE_W-1:0] = capture_i;
      A_VALUE:     rdata_o[CNT_W+PRE_W-1:0] = value_i;
      default:     rdata_o                  = '0;
    endcase
  end

  assign ctrl_o      = ctrl_q;
  assign interval_o  = interval_q;
  assign match_o     = match_q;
  assign pre_load_o  = pre_load_q;
  assign pre_match_o = pre_match_q;
  assign load_o      = load_q;
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tmr_ctrl_t        ctrl_i,
  input  logic [CNT_W-1:0] interval_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic [PRE_W-1:0] pre_load_i,
  input  logic [PRE_W-1:0] pre_match_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PRE_W-1:0] pre_o,
  output logic             to_evt_o,
  output logic             match_evt_o,
  output logic             stop_o
);
  logic [CNT_W-1:0] cnt_q, cnt_start, cnt_limit;
  logic [PRE_W-1:0] pre_q, pre_start, pre_end;
  logic             up, running, timed, tick, at_limit, cmp, cmp_q;

  assign up        = ctrl_i.count_up;
  assign running   = ctrl_i.run && (ctrl_i.mode != MODE_IDLE);
  assign timed     = (ctrl_i.mode == MODE_ONESHOT) || (ctrl_i.mode == MODE_PERIODIC);
  assign cnt_start = up ? '0 : interval_i;
  assign cnt_limit = up ? interval_i : '0;
  assign pre_start = up ? '0 : pre_load_i;
  assign pre_end   = up ? pre_load_i : '0;

  assign tick     = running && (pre_q == pre_end);
  assign at_limit = (cnt_q == cnt_limit);
  assign to_evt_o = tick && at_limit && timed && !load_i;
  assign stop_o   = to_evt_o && (ctrl_i.mode == MODE_ONESHOT);

  assign cmp = (cnt_q == match_i) && (!ctrl_i.match_pre || (pre_q == pre_match_i));
  assign match_evt_o = running && timed && ctrl_i.match_ie && cmp && !cmp_q && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pre_q <= '0;
      cmp_q <= 1'b0;
    end else begin
      cmp_q <= cmp;
      if (load_i) begin
        cnt_q <= cnt_start;
        pre_q <= pre_start;
      end else if (running && !stop_o) begin
        if (tick) begin
          pre_q <= pre_start;
          if (at_limit)  cnt_q <= cnt_start;   // periodic / edge-time wrap
          else if (up)   cnt_q <= cnt_q + 1'b1;
          else           cnt_q <= cnt_q - 1'b1;
        end else if (up) begin
          pre_q <= pre_q + 1'b1;
        end else begin
          pre_q <= pre_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign pre_o = pre_q;
endmodule

// File: rtl/tmr_capture.sv
`timescale 1ns/1ps
module tmr_capture #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cap_i,
  input  logic                   edge_mode_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic [PRE_W-1:0]       pre_i,
  input  logic [CNT_W-1:0]       match_i,
  input  logic [PRE_W-1:0]       pre_match_i,
  output logic [CNT_W+PRE_W-1:0] cap_val_o,
  output logic                   cap_evt_o
);
  localparam int unsigned SH_W = SYNC_N + 1;

  logic [SH_W-1:0]        sh_q;
  logic [CNT_W+PRE_W-1:0] cap_q;
  logic                   rise, take;

  // SYNC_N flops for metastability, one more for edge detect
  assign rise = sh_q[SH_W-2] & ~sh_q[SH_W-1];
  assign take = rise && edge_mode_i;
  assign cap_evt_o = take && (cnt_i == match_i) && (pre_i == pre_match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cap_q <= '0;
    end else begin
      sh_q <= {sh_q[SH_W-2:0], cap_i};
      if (take) cap_q <= {pre_i, cnt_i};
    end
  end

  assign cap_val_o = cap_q;
endmodule

// File: rtl/gp_timer_chan.sv
`timescale 1ns/1ps
module gp_timer_chan
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cap_i,
  input  logic              rtc_evt_i
);
  localparam int unsigned VAL_W = CNT_W + PRE_W;

  tmr_ctrl_t            ctrl;
  logic [CNT_W-1:0]     interval, match_val, cnt;
  logic [PRE_W-1:0]     pre_load, pre_match, pre;
  logic [VAL_W-1:0]     cap_val;
  logic [STATUS_W-1:0]  raw;
  logic                 load, stop, to_evt, match_evt, cap_evt;

  tmr_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .ctrl_o      (ctrl),
    .interval_o  (interval),
    .match_o     (match_val),
    .pre_load_o  (pre_load),
    .pre_match_o (pre_match),
    .load_o      (load),
    .stop_i      (stop),
    .to_evt_i    (to_evt),
    .match_evt_i (match_evt),
    .cap_evt_i   (cap_evt),
    .rtc_evt_i   (rtc_evt_i),
    .value_i     ({pre, cnt}),
    .capture_i   (cap_val),
    .raw_o       (raw)
  );

  tmr_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .interval_i  (interval),
    .match_i     (match_val),
    .pre_load_i  (pre_load),
    .pre_match_i (pre_match),
    .load_i      (load),
    .cnt_o       (cnt),
    .pre_o       (pre),
    .to_evt_o    (to_evt),
    .match_evt_o (match_evt),
    .stop_o      (stop)
  );

  tmr_capture #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap_i),
    .edge_mode_i (ctrl.mode == MODE_EDGE_TIME),
    .cnt_i       (cnt),
    .pre_i       (pre),
    .match_i     (match_val),
    .pre_match_i (pre_match),
    .cap_val_o   (cap_val),
    .cap_evt_o   (cap_evt)
  );
endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                rtc_evt_i,
  input tmr_ctrl_t           ctrl_i,
  input logic [STATUS_W-1:0] raw_i,
  input logic                to_evt_i,
  input logic                match_evt_i,
  input logic                cap_evt_i
);
  logic clr_to, wr_ctrl, unused_chk;
  assign clr_to     = wr_en_i && (addr_i == A_CLEAR) && wdata_i[8];
  assign wr_ctrl    = wr_en_i && (addr_i == A_CTRL);
  assign unused_chk = ^{wdata_i, raw_i};

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_STATUS) |-> (rdata_o[DATA_W-1:STATUS_W] == '0 && rdata_o[7:5] == '0
                              && rdata_o[2:0] == '0));

  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_evt_i |=> raw_i[8]);

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_to && !to_evt_i) |=> !raw_i[8]);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i[8] && !clr_to) |=> raw_i[8]);

  p_oneshot_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_evt_i && ctrl_i.mode == MODE_ONESHOT && !wr_ctrl) |=> !ctrl_i.run);

  p_match_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_evt_i |-> (ctrl_i.match_ie &&
                     (ctrl_i.mode == MODE_ONESHOT || ctrl_i.mode == MODE_PERIODIC)));

  p_match_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_i[4]) |-> $past(match_evt_i));

  p_cap_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |-> (ctrl_i.mode == MODE_EDGE_TIME));

  p_cap_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_i[9]) |-> $past(cap_evt_i));

  p_rtc_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtc_evt_i |=> raw_i[3]);
endmodule

bind gp_timer_chan tmr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .rtc_evt_i   (rtc_evt_i),
  .ctrl_i      (ctrl),
  .raw_i       (raw),
  .to_evt_i    (to_evt),
  .match_evt_i (match_evt),
  .cap_evt_i   (cap_evt)
);

// File: tb/tb_gp_timer_chan.sv
`timescale 1ns/1ps
module tb_gp_timer_chan;
  import tmr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cap = 1'b0;
  logic        rtc = 1'b0;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  gp_timer_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .rtc_evt_i(rtc)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #0.5;
    chk(rdata, exp, tag);
  endtask

  task automatic stop_clear();
    wr(A_CTRL, 32'h0);
    wr(A_CLEAR, 32'h3FF);
  endtask

  task automatic pulse_cap();
    @(negedge clk); cap = 1'b1;
    repeat (3) @(negedge clk);
    cap = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    expect_reg(A_STATUS, 32'h0, "R2 status after reset");
    expect_reg(A_CTRL, 32'h0, "R2 control after reset");
    expect_reg(A_VALUE, 32'h0, "R2 value after reset");
    expect_reg(A_CAPTURE, 32'h0, "R2 capture after reset");
  endtask

  task automatic t_oneshot_down();
    stop_clear();
    wr(A_INTERVAL, 3);
    wr(A_PRE_LOAD, 0);
    wr(A_CTRL, 32'h21);
    @(negedge clk);
    expect_reg(A_VALUE, 32'd3, "R12 down start value");
    repeat (3) @(negedge clk);
    expect_reg(A_STATUS, 32'h0, "R4 no time-out before limit");
    @(negedge clk);
    expect_reg(A_STATUS, 32'h100, "R4 down time-out at zero");
    expect_reg(A_CTRL, 32'h01, "R5 one-shot clears run");
    repeat (3) @(negedge clk);
    expect_reg(A_VALUE, 32'h0, "R5 one-shot holds counter");
  endtask

  task automatic t_clear();
    wr(A_CLEAR, 32'h0);
    expect_reg(A_STATUS, 32'h100, "R3 zero clear no effect");
    wr(A_CLEAR, 32'h10);
    expect_reg(A_STATUS, 32'h100, "R3 other-bit clear no effect");
    wr(A_CLEAR, 32'h100);
    expect_reg(A_STATUS, 32'h0, "R3 clear time-out");
  endtask

  task automatic t_periodic_up();
    stop_clear();
    wr(A_INTERVAL, 2);
    wr(A_PRE_LOAD, 1);
    wr(A_CTRL, 32'h26);
    repeat (6) @(negedge clk);
    expect_reg(A_STATUS, 32'h0, "R4 up no early time-out");
    @(negedge clk);
    expect_reg(A_STATUS, 32'h100, "R4 up time-out at interval");
    expect_reg(A_VALUE, 32'h0, "R5 periodic reload");
    @(negedge clk);
    expect_reg(A_VALUE, 32'h10000, "R11 up prescaler runs after reload");
    expect_reg(A_CTRL, 32'h26, "R5 periodic keeps run");
    stop_clear();
  endtask

  task automatic t_prescale();
    stop_clear();
    wr(A_INTERVAL, 1);
    wr(A_PRE_LOAD, 3);
    wr(A_CTRL, 32'h21);
    repeat (5) @(negedge clk);
    expect_reg(A_VALUE, 32'h30000, "R11 counter steps after load+1 cycles");
    repeat (3) @(negedge clk);
    expect_reg(A_STATUS, 32'h0, "R11 no time-out before prescaled limit");
    @(negedge clk);
    expect_reg(A_STATUS, 32'h100, "R11 prescaled time-out");
  endtask

  task automatic t_match_gate();
    stop_clear();
    wr(A_INTERVAL, 5); wr(A_PRE_LOAD, 0); wr(A_MATCH, 2); wr(A_PRE_MATCH, 0);
    wr(A_CTRL, 32'h21);
    repeat (10) @(negedge clk);
    expect_reg(A_STATUS, 32'h100, "R6 no match without enable");
    stop_clear();
    wr(A_CTRL, 32'h29);
    repeat (10) @(negedge clk);
    expect_reg(A_STATUS, 32'h110, "R6 match with enable");
  endtask

  task automatic t_match_pre();
    stop_clear();
    wr(A_PRE_LOAD, 2); wr(A_INTERVAL, 3); wr(A_MATCH, 1); wr(A_PRE_MATCH, 5);
    wr(A_CTRL, 32'h39);
    repeat (20) @(negedge clk);
    expect_reg(A_STATUS, 32'h100, "R7 prescaler mismatch blocks match");
    stop_clear();
    wr(A_CTRL, 32'h29);
    repeat (20) @(negedge clk);
    expect_reg(A_STATUS, 32'h110, "R7 prescaler ignored when off");
    stop_clear();
    wr(A_PRE_MATCH, 1);
    wr(A_CTRL, 32'h39);
    repeat (20) @(negedge clk);
    expect_reg(A_STATUS, 32'h110, "R7 prescaler included match");
  endtask

  task automatic t_capture();
    logic [31:0] c;
    stop_clear();
    wr(A_INTERVAL, 40); wr(A_PRE_LOAD, 7); wr(A_MATCH, 40); wr(A_PRE_MATCH, 7);
    wr(A_CTRL, 32'h03);
    pulse_cap();
    expect_reg(A_CAPTURE, 32'h70028, "R8 capture latched");
    expect_reg(A_STATUS, 32'h200, "R9 capture match");
    wr(A_CLEAR, 32'h200);
    wr(A_MATCH, 41);
    pulse_cap();
    expect_reg(A_STATUS, 32'h0, "R9 no capture match on mismatch");
    wr(A_INTERVAL, 9);
    wr(A_CTRL, 32'h01);
    pulse_cap();
    expect_reg(A_CAPTURE, 32'h70028, "R8 capture ignored outside edge mode");
    stop_clear();
    wr(A_INTERVAL, 2); wr(A_PRE_LOAD, 0); wr(A_MATCH, 1);
    wr(A_CTRL, 32'h2B);
    repeat (20) @(negedge clk);
    pulse_cap();
    addr = A_CAPTURE; #0.5; c = rdata;
    chk({31'b0, c <= 32'd2}, 32'd1, "R8 running capture within wrap range");
    expect_reg(A_STATUS, 32'h0, "R4 R6 edge mode raises no time-out or match");
    stop_clear();
  endtask

  task automatic t_rtc();
    stop_clear();
    @(negedge clk); rtc = 1'b1;
    @(negedge clk); rtc = 1'b0;
    expect_reg(A_STATUS, 32'h8, "R10 rtc event sets bit 3");
    @(negedge clk);
    rtc = 1'b1; wr_en = 1'b1; addr = A_CLEAR; wdata = 32'h8;
    @(negedge clk);
    rtc = 1'b0; wr_en = 1'b0;
    expect_reg(A_STATUS, 32'h8, "R3 set wins over clear");
    wr(A_CLEAR, 32'h8);
    expect_reg(A_STATUS, 32'h0, "R3 rtc bit cleared");
  endtask

  task automatic t_status_ro();
    stop_clear();
    @(negedge clk); rtc = 1'b1;
    @(negedge clk); rtc = 1'b0;
    wr(A_STATUS, 32'hFFFF_FFFF);
    expect_reg(A_STATUS, 32'h8, "R1 status read-only");
    wr(A_CLEAR, 32'hFFFF_FFFF);
    expect_reg(A_STATUS, 32'h0, "R1 reserved bits stay zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_oneshot_down();
    t_clear();
    t_periodic_up();
    t_prescale();
    t_match_gate();
    t_match_pre();
    t_capture();
    t_rtc();
    t_status_ro();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule